// File: doc/BRIEF.md
# DDR3 Refresh and Mode Timing Calculator

This block turns three configuration values (the DRAM clock in MHz, the device density in megabits and the CAS latency) into two words for a DDR3 memory controller. The refresh word carries the refresh cycle time and the average refresh interval, both counted in DRAM clocks. The mode word carries the MR0 CAS and write-recovery fields. Boot firmware or a configuration sequencer writes the inputs, pulses `start`, and copies the two words into the controller when `done` pulses.

The refresh cycle time comes from a density table in nanoseconds. The refresh cycle time and the write recovery (15 ns) are each converted to clocks by a multiply and a ceiling divide by 1000. The divide is a restoring divider that works one bit per cycle, and a single divider instance serves both conversions. The refresh interval is the clock multiplied by 7987 and shifted right by 10, which keeps it at or under 7.8 us.

The controller is a state machine with these states:
- `ST_IDLE` waits and accepts `start`. The transition IDLE->RFC_GO latches the inputs.
- `ST_RFC_GO` loads the divider. The transition RFC_GO->RFC_WAIT follows.
- `ST_RFC_WAIT` runs until the divider finishes. The transition RFC_WAIT->WR_GO captures tRFC.
- `ST_WR_GO` loads the divider a second time. The transition WR_GO->WR_WAIT follows.
- `ST_WR_WAIT` ends with the transition WR_WAIT->PACK, which captures the write-recovery count.
- `ST_PACK` registers the output words and raises `done`. The transition PACK->IDLE follows.

Top module: `ddr3_tcalc`

## Requirements
- R1: While reset is low, and after it is released, `busy`, `done`, `refresh_word`, `mode_word` and `field_ovf` are all 0.
- R2: The density sets the refresh cycle time in ns as follows:
  - 256 and 512 give 90.
  - 1024 gives 110.
  - 2048 gives 160.
  - 4096 gives 300.
  - 8192 gives 350.
  - Any other density value gives 90.
- R3: `refresh_word[7:0]` holds the low 8 bits of tRFC in clocks, where tRFC = (ns * MHz + 999) / 1000 with integer division.
- R4: `refresh_word[23:8]` holds the low 16 bits of tREFI, where tREFI = (7987 * MHz) >> 10.
- R5: `field_ovf` is 1 exactly when tRFC exceeds 255 or tREFI exceeds 65535.
- R6: With the write-recovery count n = (15 * MHz + 999) / 1000, `mode_word[11:9]` holds the write-recovery code:
  - 1 when n is below 5.
  - n - 4 when n is 5 to 8.
  - 5 when n is 9 or 10.
  - 6 when n is above 10.
- R7: `mode_word[6:4]` is the CAS latency minus 4. The burst-length bits [1:0] and every other bit of `mode_word` are 0.
- R8: A `start` seen with `busy` low latches the inputs, and `busy` is 1 in the next cycle. `done` is a one-cycle pulse with `busy` low, and the new words appear in that same cycle.
- R9: The output words and `field_ovf` change only in a cycle where `done` is 1. Input changes and `start` pulses while `busy` is 1 have no effect on the result.
- R10: A `start` held high in the cycle where `done` is 1 is accepted, and the next calculation begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a calculation |
| dram_mhz | input | 12 | DRAM clock in MHz |
| density_mb | input | 14 | Device density in megabits |
| cas_lat | input | 4 | CAS latency in clocks (5 to 11) |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| refresh_word | output | 24 | {tREFI[15:0], tRFC[7:0]} |
| mode_word | output | 16 | MR0 image: write recovery [11:9], CAS [6:4] |
| field_ovf | output | 1 | A refresh value did not fit its field |

## Verification
Result publication and acceptance of a new request can fall in the same cycle. This happens when `start` is held high through the end of a calculation, because the `done` cycle is already an idle cycle. The bench holds `start` high and switches the inputs at the `done` edge. It then checks three things:
- The words shown with `done` belong to the first request.
- `busy` rises in the next cycle.
- The following `done` brings the second request's results.

Stability between pulses and refusal of requests during `busy` are judged by comparing the output words against the earlier request's expected values.

// File: rtl/ddr3_tcalc_pkg.sv
package ddr3_tcalc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RFC_GO,
        ST_RFC_WAIT,
        ST_WR_GO,
        ST_WR_WAIT,
        ST_PACK
    } calc_state_t;

    localparam int NS_W       = 9;
    localparam int DIVISOR    = 1000;
    localparam int ROUND_ADD  = DIVISOR - 1;
    localparam int REFI_MUL   = 7987;
    localparam int REFI_SHIFT = 10;
    localparam int TWR_NS     = 15;

    localparam int DENS_CODES = 6;
    localparam int DENS_BASE  = 256;

    typedef logic [NS_W-1:0] ns_t;
    localparam ns_t RFC_NS [DENS_CODES] = '{9'd90, 9'd90, 9'd110, 9'd160, 9'd300, 9'd350};

    localparam int MR_CAS_LSB = 4;
    localparam int MR_WR_LSB  = 9;

endpackage

// File: rtl/ddr3_tcalc_rfc_lut.sv
module ddr3_tcalc_rfc_lut
    import ddr3_tcalc_pkg::*;
#(
    parameter int DENS_W = 14
) (
    input  logic [DENS_W-1:0] density_mb,
    output logic [NS_W-1:0]   trfc_ns
);

    always_comb begin
        trfc_ns = RFC_NS[0];
        for (int k = 0; k < DENS_CODES; k++) begin
            if (32'(density_mb) == (DENS_BASE << k)) begin
                trfc_ns = RFC_NS[k];
            end
        end
    end

endmodule

// File: rtl/ddr3_tcalc_div1000.sv
module ddr3_tcalc_div1000
    import ddr3_tcalc_pkg::*;
#(
    parameter int NUM_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    output logic [NUM_W-1:0] quot,
    output logic             fin
);

    localparam int REM_W = $clog2(2 * DIVISOR);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [REM_W-1:0] DIV_V = DIVISOR[REM_W-1:0];

    logic [NUM_W-1:0] q_sr;
    logic [REM_W-1:0] rem;
    logic [CNT_W-1:0] cnt;
    logic             active;
    logic [REM_W-1:0] trial;
    logic             fits;

    always_comb begin
        trial = {rem[REM_W-2:0], q_sr[NUM_W-1]};
        fits  = (trial >= DIV_V);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_sr   <= '0;
            rem    <= '0;
            cnt    <= '0;
            active <= 1'b0;
            fin    <= 1'b0;
        end else if (go) begin
            q_sr   <= num;
            rem    <= '0;
            cnt    <= CNT_W'(NUM_W);
            active <= 1'b1;
            fin    <= 1'b0;
        end else if (active) begin
            q_sr <= {q_sr[NUM_W-2:0], fits};
            rem  <= fits ? (trial - DIV_V) : trial;
            cnt  <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
                active <= 1'b0;
                fin    <= 1'b1;
            end
        end else begin
            fin <= 1'b0;
        end
    end

    assign quot = q_sr;

endmodule

// File: rtl/ddr3_tcalc_wr_enc.sv
module ddr3_tcalc_wr_enc #(
    parameter int CNT_W = 21
) (
    input  logic [CNT_W-1:0] twr_ck,
    output logic [2:0]       wr_code
);

    always_comb begin
        if (twr_ck < CNT_W'(5)) begin
            wr_code = 3'd1;
        end else if (twr_ck <= CNT_W'(8)) begin
            wr_code = 3'(twr_ck - CNT_W'(4));
        end else if (twr_ck <= CNT_W'(10)) begin
            wr_code = 3'd5;
        end else begin
            wr_code = 3'd6;
        end
    end

endmodule

// File: rtl/ddr3_tcalc.sv
module ddr3_tcalc
    import ddr3_tcalc_pkg::*;
#(
    parameter int CLK_W        = 12,
    parameter int DENS_W       = 14,
    parameter int CAS_W        = 4,
    parameter int RFC_FIELD_W  = 8,
    parameter int REFI_FIELD_W = 16,
    parameter int MODE_W       = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic [CLK_W-1:0]                    dram_mhz,
    input  logic [DENS_W-1:0]                   density_mb,
    input  logic [CAS_W-1:0]                    cas_lat,
    output logic                                busy,
    output logic                                done,
    output logic [RFC_FIELD_W+REFI_FIELD_W-1:0] refresh_word,
    output logic [MODE_W-1:0]                   mode_word,
    output logic                                field_ovf
);

    localparam int NUM_W = CLK_W + NS_W;
    localparam logic [31:0] RFC_LIMIT  = 32'd1 << RFC_FIELD_W;
    localparam logic [31:0] REFI_LIMIT = 32'd1 << REFI_FIELD_W;

    calc_state_t state, state_nx;

    logic [CLK_W-1:0] mhz_q;
    logic [NS_W-1:0]  ns_q;
    logic [CAS_W-1:0] cas_q;
    logic [NUM_W-1:0] trfc_q;
    logic [NUM_W-1:0] twr_q;
    logic [NS_W-1:0]  ns_lookup;
    logic [NUM_W-1:0] div_num;
    logic [NUM_W-1:0] div_quot;
    logic             div_go;
    logic             div_fin;
    logic [2:0]       wr_code;
    logic [31:0]      trfc32;
    logic [31:0]      trefi32;
    logic [MODE_W-1:0] mode_nx;

    ddr3_tcalc_rfc_lut #(.DENS_W(DENS_W)) u_lut (
        .density_mb (density_mb),
        .trfc_ns    (ns_lookup)
    );

    ddr3_tcalc_div1000 #(.NUM_W(NUM_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .quot  (div_quot),
        .fin   (div_fin)
    );

    ddr3_tcalc_wr_enc #(.CNT_W(NUM_W)) u_wr (
        .twr_ck  (twr_q),
        .wr_code (wr_code)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = ST_RFC_GO;
            ST_RFC_GO:   state_nx = ST_RFC_WAIT;
            ST_RFC_WAIT: if (div_fin) state_nx = ST_WR_GO;
            ST_WR_GO:    state_nx = ST_WR_WAIT;
            ST_WR_WAIT:  if (div_fin) state_nx = ST_PACK;
            ST_PACK:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        div_go  = (state == ST_RFC_GO) || (state == ST_WR_GO);
        div_num = (state == ST_WR_GO)
                ? NUM_W'(TWR_NS) * NUM_W'(mhz_q) + NUM_W'(ROUND_ADD)
                : NUM_W'(ns_q)   * NUM_W'(mhz_q) + NUM_W'(ROUND_ADD);
        trfc32  = 32'(trfc_q);
        trefi32 = (32'(REFI_MUL) * 32'(mhz_q)) >> REFI_SHIFT;
        mode_nx = '0;
        mode_nx[MR_CAS_LSB +: 3] = 3'(cas_q - CAS_W'(4));
        mode_nx[MR_WR_LSB  +: 3] = wr_code;
    end

    assign busy = (state != ST_IDLE);

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mhz_q        <= '0;
            ns_q         <= '0;
            cas_q        <= '0;
            trfc_q       <= '0;
            twr_q        <= '0;
            done         <= 1'b0;
            refresh_word <= '0;
            mode_word    <= '0;
            field_ovf    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        mhz_q <= dram_mhz;
                        ns_q  <= ns_lookup;
                        cas_q <= cas_lat;
                    end
                end
                ST_RFC_WAIT: if (div_fin) trfc_q <= div_quot;
                ST_WR_WAIT:  if (div_fin) twr_q  <= div_quot;
                ST_PACK: begin
                    refresh_word <= {trefi32[REFI_FIELD_W-1:0], trfc32[RFC_FIELD_W-1:0]};
                    mode_word    <= mode_nx;
                    field_ovf    <= (trfc32 >= RFC_LIMIT) || (trefi32 >= REFI_LIMIT);
                    done         <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ddr3_tcalc_chk.sv
module ddr3_tcalc_chk #(
    parameter int WORD_W = 24,
    parameter int MODE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] refresh_word,
    input logic [MODE_W-1:0] mode_word,
    input logic              field_ovf
);

    localparam logic [MODE_W-1:0] USED_BITS = (MODE_W'(7) << 4) | (MODE_W'(7) << 9);

    // R8: a request accepted from idle makes the block busy next cycle
    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8: done is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done is never raised while busy
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: results change only with done
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(refresh_word) && $stable(mode_word) && $stable(field_ovf)));

    // R7: nothing outside the CAS and write-recovery fields is set
    assert_mode_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_word & ~USED_BITS) == '0);

    // R6: published write-recovery code lies in 1..6
    assert_wr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mode_word[11:9] >= 3'd1 && mode_word[11:9] <= 3'd6));

endmodule

bind ddr3_tcalc ddr3_tcalc_chk #(
    .WORD_W (RFC_FIELD_W + REFI_FIELD_W),
    .MODE_W (MODE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .refresh_word (refresh_word),
    .mode_word    (mode_word),
    .field_ovf    (field_ovf)
);

// File: tb/ddr3_tcalc_test.sv
module ddr3_tcalc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] dram_mhz = '0;
    logic [13:0] density_mb = '0;
    logic [3:0]  cas_lat = '0;
    logic        busy;
    logic        done;
    logic [23:0] refresh_word;
    logic [15:0] mode_word;
    logic        field_ovf;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ddr3_tcalc uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .dram_mhz     (dram_mhz),
        .density_mb   (density_mb),
        .cas_lat      (cas_lat),
        .busy         (busy),
        .done         (done),
        .refresh_word (refresh_word),
        .mode_word    (mode_word),
        .field_ovf    (field_ovf)
    );

    // {mhz[70:59], density[58:45], cas[44:41], refresh[40:17], mode[16:1], ovf[0]}
    localparam int NV = 11;
    localparam logic [70:0] VEC [NV] = '{
        {12'd384, 14'd1024, 4'd9,  24'h0BB32B, 16'h0450, 1'b0},
        {12'd533, 14'd2048, 4'd7,  24'h103D56, 16'h0830, 1'b0},
        {12'd648, 14'd4096, 4'd11, 24'h13BEC3, 16'h0A70, 1'b0},
        {12'd312, 14'd777,  4'd6,  24'h09811D, 16'h0220, 1'b0},
        {12'd200, 14'd512,  4'd5,  24'h061712, 16'h0210, 1'b0},
        {12'd800, 14'd8192, 4'd11, 24'h185F18, 16'h0C70, 1'b1},
        {12'd256, 14'd256,  4'd5,  24'h07CC18, 16'h0210, 1'b0},
        {12'd1000,14'd256,  4'd8,  24'h1E775A, 16'h0C40, 1'b0},
        {12'd560, 14'd1024, 4'd8,  24'h110F3E, 16'h0A40, 1'b0},
        {12'd728, 14'd8192, 4'd10, 24'h162EFF, 16'h0C60, 1'b0},
        {12'd729, 14'd8192, 4'd10, 24'h163600, 16'h0C60, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [70:0] v);
        dram_mhz   = v[70:59];
        density_mb = v[58:45];
        cas_lat    = v[44:41];
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk("R8 done timeout", 32'd0, 32'd1);
    endtask

    task automatic compare(input logic [70:0] v, input string tag);
        chk({tag, " R2/R3 tRFC field"}, 32'(refresh_word[7:0]), 32'(v[24:17]));
        chk({tag, " R4 tREFI field"}, 32'(refresh_word[23:8]), 32'(v[40:25]));
        chk({tag, " R5 overflow"}, 32'(field_ovf), 32'(v[0]));
        chk({tag, " R6 write recovery"}, 32'(mode_word[11:9]), 32'(v[12:10]));
        chk({tag, " R7 mode word"}, 32'(mode_word), 32'(v[16:1]));
    endtask

    task automatic run_vec(input logic [70:0] v, input string tag);
        @(negedge clk);
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R8 busy after start"}, 32'(busy), 32'd1);
        wait_done();
        chk({tag, " R8 idle with done"}, 32'(busy), 32'd0);
        compare(v, tag);
        @(negedge clk);
        chk({tag, " R8 done pulse width"}, 32'(done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] held_r;
        logic [15:0] held_m;
        int          seen;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 refresh", 32'(refresh_word), 32'd0);
        chk("R1 mode", 32'(mode_word), 32'd0);
        chk("R1 ovf", 32'(field_ovf), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'(refresh_word) | 32'(busy), 32'd0);

        // Table walk (R2..R8)
        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], $sformatf("vec%0d", i));
        end

        // R9: inputs and start while busy are ignored
        @(negedge clk);
        drive(VEC[0]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        drive(VEC[5]);
        start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        wait_done();
        compare(VEC[0], "R9 ignore-busy");

        // R10: start held through done begins a new calculation
        repeat (2) @(negedge clk);
        drive(VEC[1]);
        start = 1'b1;
        @(negedge clk);
        wait_done();
        compare(VEC[1], "R10 first");
        drive(VEC[2]);
        @(negedge clk);
        chk("R10 busy after done-cycle start", 32'(busy), 32'd1);
        start = 1'b0;
        wait_done();
        compare(VEC[2], "R10 second");

        // R9: outputs hold with no request while inputs move
        held_r = refresh_word;
        held_m = mode_word;
        seen = 0;
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            drive(VEC[k % NV]);
            @(negedge clk);
            if (done) seen++;
        end
        chk("R9 refresh held", 32'(refresh_word), 32'(held_r));
        chk("R9 mode held", 32'(mode_word), 32'(held_m));
        chk("R9 no spurious done", 32'(seen), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule